// File: doc/BRIEF.md
# IPv4 Longest-Prefix Forwarding Stage

This block is one match-action step of a packet pipeline. Each cycle that a parsed IPv4 header is valid, it compares the 32-bit destination address with every entry of a small route table at once. The matching entry with the longest prefix wins. The winner's action either discards the packet or forwards it. Forwarding writes a next-hop address and an egress port into the packet metadata and lowers the header's TTL by one. The result is registered, so it appears one cycle after the key is presented.

The control plane fills the table through a single write port. Each write carries the slot index, a valid flag, the prefix, the prefix length, the action code, the next-hop address and the port. The data path only reads the table and never changes it. A prefix of length zero matches every address, so such an entry acts as the default route.

Top module: `lpm_fwd_stage`

## Requirements
- R1: While rst_n is low and after it is released, every table slot is invalid and out_vld, out_drop, out_hit, out_nhop, out_port and out_ttl all read zero.
- R2: A lookup presented with in_vld high on one rising edge appears on the outputs after that edge, with out_vld high.
- R3: A slot matches when it is valid and the top L bits of its prefix equal the top L bits of in_dst, where L is its length. L = 0 matches every address, and any length above 32 behaves as 32.
- R4: When several slots match, the slot with the greatest effective length is used. Among slots of equal length, the lowest index wins.
- R5: A lookup that matches no slot gives out_hit = 0 and applies the discard action.
- R6: The discard action (action code 0, or a miss) gives out_drop = 1, out_nhop = 0, out_port = 0, and out_ttl equal to in_ttl.
- R7: The forward action (action code 1) gives out_drop = 0, out_hit = 1, and the slot's next hop and port on out_nhop and out_port. It also gives out_ttl = in_ttl minus 1 modulo 256, so 0 becomes 255.
- R8: When cp_wr_en is high on an edge, slot cp_wr_idx takes the written fields. cp_wr_valid = 0 removes the slot. A lookup on the same edge still sees the old contents, and lookups never alter any slot.
- R9: When in_vld is low on an edge, out_vld is low after it and every other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_wr_en | input | 1 | Control-plane write strobe |
| cp_wr_idx | input | 4 | Slot to write |
| cp_wr_valid | input | 1 | Valid flag of the written slot |
| cp_wr_prefix | input | 32 | Prefix value |
| cp_wr_len | input | 6 | Prefix length, 0 to 32 (larger acts as 32) |
| cp_wr_act | input | 1 | Action code: 0 discard, 1 forward |
| cp_wr_nhop | input | 32 | Next-hop address parameter |
| cp_wr_port | input | 4 | Egress port parameter |
| in_vld | input | 1 | IPv4 header valid, starts a lookup |
| in_dst | input | 32 | Destination address key |
| in_ttl | input | 8 | TTL field of the header |
| out_vld | output | 1 | Registered result valid |
| out_drop | output | 1 | Packet discarded |
| out_hit | output | 1 | Some slot matched |
| out_nhop | output | 32 | Next-hop address metadata |
| out_port | output | 4 | Egress port metadata |
| out_ttl | output | 8 | Edited TTL |

## Verification
The bench builds the stage with its default values: 16 slots, 32-bit keys and 4-bit ports. At that size one nested chain of prefixes with lengths 2 to 32 reaches every depth of prefix agreement. The bench then sweeps keys that agree with the chain's base for exactly k leading bits, for every k from 0 to 32, so every length comparison in the priority logic is exercised. The sweep runs with and without a zero-length default route. Scrambled keys, ties of equal length, removal of a slot, a write that coincides with a lookup, and the TTL wrap at zero cover the remaining corners.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;
    localparam int PORT_W = 4;
    localparam int TTL_W  = 8;

    typedef enum logic {
        ACT_DROP = 1'b0,
        ACT_NHOP = 1'b1
    } act_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] prefix;
        logic [LEN_W-1:0]  len;
        act_e              act;
        logic [ADDR_W-1:0] nhop;
        logic [PORT_W-1:0] port;
    } entry_t;

    // Bit b is kept when it lies inside the top len bits; lengths past ADDR_W keep all.
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if ((ADDR_W - b) <= int'(len)) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] len);
        return (int'(len) > ADDR_W) ? LEN_W'(ADDR_W) : len;
    endfunction

endpackage

// File: rtl/lpm_table.sv
module lpm_table
    import lpm_pkg::*;
#(
    parameter  int N_ENTRIES = 16,
    localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    output entry_t           ents [N_ENTRIES]
);

    entry_t tbl_d [N_ENTRIES];
    entry_t tbl_q [N_ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < N_ENTRIES)) tbl_d[wr_idx] = wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign ents = tbl_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
        AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (ents[g] == $past(wr_entry)));  // R8
        AST_SLOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ents[g]));  // R8
    end

endmodule

// File: rtl/lpm_match.sv
module lpm_match
    import lpm_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic              rst_n,
    input  entry_t            ents [N_ENTRIES],
    input  logic [ADDR_W-1:0] key,
    output logic              hit,
    output entry_t            best
);

    logic [N_ENTRIES-1:0] mvec;
    logic [LEN_W-1:0]     elen [N_ENTRIES];
    logic [LEN_W-1:0]     best_len;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign elen[g] = eff_len(ents[g].len);
        assign mvec[g] = ents[g].valid &&
                         (((key ^ ents[g].prefix) & len_mask(ents[g].len)) == '0);
    end

    // Scan upward: a strictly longer match replaces, so ties keep the lower index.
    always_comb begin
        hit      = 1'b0;
        best     = '0;
        best_len = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (mvec[i] && (!hit || elen[i] > best_len)) begin
                hit      = 1'b1;
                best     = ents[i];
                best_len = elen[i];
            end
        end
    end

    always_comb begin
        if (rst_n) begin
            for (int j = 0; j < N_ENTRIES; j++) begin
                if (mvec[j]) begin
                    AST_LONGEST: assert (hit && eff_len(best.len) >= elen[j]);  // R4
                end
            end
        end
    end

endmodule

// File: rtl/lpm_action.sv
module lpm_action
    import lpm_pkg::*;
(
    input  logic              hit,
    input  entry_t            sel,
    input  logic [TTL_W-1:0]  ttl_in,
    output logic              drop,
    output logic [ADDR_W-1:0] nhop,
    output logic [PORT_W-1:0] port,
    output logic [TTL_W-1:0]  ttl_out
);

    logic fwd;

    always_comb begin
        fwd     = hit && (sel.act == ACT_NHOP);
        drop    = !fwd;
        nhop    = fwd ? sel.nhop : '0;
        port    = fwd ? sel.port : '0;
        ttl_out = fwd ? TTL_W'(ttl_in - 1'b1) : ttl_in;
    end

endmodule

// File: rtl/lpm_fwd_stage.sv
module lpm_fwd_stage
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_en,
    input  logic [3:0]        cp_wr_idx,
    input  logic              cp_wr_valid,
    input  logic [ADDR_W-1:0] cp_wr_prefix,
    input  logic [LEN_W-1:0]  cp_wr_len,
    input  logic              cp_wr_act,
    input  logic [ADDR_W-1:0] cp_wr_nhop,
    input  logic [PORT_W-1:0] cp_wr_port,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_dst,
    input  logic [TTL_W-1:0]  in_ttl,
    output logic              out_vld,
    output logic              out_drop,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_nhop,
    output logic [PORT_W-1:0] out_port,
    output logic [TTL_W-1:0]  out_ttl
);

    localparam int N_ENTRIES = 16;

    typedef struct packed {
        logic              vld;
        logic              drop;
        logic              hit;
        logic [ADDR_W-1:0] nhop;
        logic [PORT_W-1:0] port;
        logic [TTL_W-1:0]  ttl;
    } res_t;

    entry_t            wr_entry;
    entry_t            ents [N_ENTRIES];
    entry_t            best;
    logic              m_hit;
    logic              a_drop;
    logic [ADDR_W-1:0] a_nhop;
    logic [PORT_W-1:0] a_port;
    logic [TTL_W-1:0]  a_ttl;
    res_t              res_d;
    res_t              res_q;

    always_comb begin
        wr_entry.valid  = cp_wr_valid;
        wr_entry.prefix = cp_wr_prefix;
        wr_entry.len    = cp_wr_len;
        wr_entry.act    = act_e'(cp_wr_act);
        wr_entry.nhop   = cp_wr_nhop;
        wr_entry.port   = cp_wr_port;
    end

    lpm_table #(.N_ENTRIES(N_ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cp_wr_en),
        .wr_idx   (cp_wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .rst_n (rst_n),
        .ents  (ents),
        .key   (in_dst),
        .hit   (m_hit),
        .best  (best)
    );

    lpm_action u_action (
        .hit     (m_hit),
        .sel     (best),
        .ttl_in  (in_ttl),
        .drop    (a_drop),
        .nhop    (a_nhop),
        .port    (a_port),
        .ttl_out (a_ttl)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        if (in_vld) begin
            res_d.vld  = 1'b1;
            res_d.drop = a_drop;
            res_d.hit  = m_hit;
            res_d.nhop = a_nhop;
            res_d.port = a_port;
            res_d.ttl  = a_ttl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld  = res_q.vld;
    assign out_drop = res_q.drop;
    assign out_hit  = res_q.hit;
    assign out_nhop = res_q.nhop;
    assign out_port = res_q.port;
    assign out_ttl  = res_q.ttl;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);  // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_drop) && $stable(out_hit) &&
                     $stable(out_nhop) && $stable(out_port) && $stable(out_ttl)));  // R9
    AST_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_hit) |-> out_drop);  // R5
    AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld ##1 (out_vld && out_drop)) |->
            (out_nhop == '0 && out_port == '0 && out_ttl == $past(in_ttl)));  // R6
    AST_TTL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld ##1 (out_vld && !out_drop)) |->
            (out_hit && out_ttl == TTL_W'($past(in_ttl) - 1'b1)));  // R7

endmodule

// File: tb/sim_lpm_fwd_stage.sv
module sim_lpm_fwd_stage;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam logic [31:0] BASE = 32'h0A5C_3F96;
    localparam logic [31:0] TIEP = 32'hC633_6400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cp_wr_en, cp_wr_valid, cp_wr_act;
    logic [3:0]  cp_wr_idx, cp_wr_port;
    logic [31:0] cp_wr_prefix, cp_wr_nhop;
    logic [5:0]  cp_wr_len;
    logic        in_vld;
    logic [31:0] in_dst;
    logic [7:0]  in_ttl;
    logic        out_vld, out_drop, out_hit;
    logic [31:0] out_nhop;
    logic [3:0]  out_port;
    logic [7:0]  out_ttl;

    int checks = 0;
    int errors = 0;

    // bench copy of the table, filled from what the bench writes
    logic        m_valid [NS];
    logic [31:0] m_prefix[NS];
    logic [5:0]  m_len   [NS];
    logic        m_act   [NS];
    logic [31:0] m_nhop  [NS];
    logic [3:0]  m_port  [NS];

    logic        e_vld, e_drop, e_hit;
    logic [31:0] e_nhop;
    logic [3:0]  e_port;
    logic [7:0]  e_ttl;

    lpm_fwd_stage u0 (
        .clk(clk), .rst_n(rst_n),
        .cp_wr_en(cp_wr_en), .cp_wr_idx(cp_wr_idx), .cp_wr_valid(cp_wr_valid),
        .cp_wr_prefix(cp_wr_prefix), .cp_wr_len(cp_wr_len), .cp_wr_act(cp_wr_act),
        .cp_wr_nhop(cp_wr_nhop), .cp_wr_port(cp_wr_port),
        .in_vld(in_vld), .in_dst(in_dst), .in_ttl(in_ttl),
        .out_vld(out_vld), .out_drop(out_drop), .out_hit(out_hit),
        .out_nhop(out_nhop), .out_port(out_port), .out_ttl(out_ttl)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic ref_calc(input logic [31:0] dst, input logic [7:0] ttl);
        int best = -1;
        int bl = -1;
        for (int i = 0; i < NS; i++) begin
            int l = (m_len[i] > 32) ? 32 : int'(m_len[i]);
            logic [31:0] mask = (l == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - l));
            if (m_valid[i] && ((dst ^ m_prefix[i]) & mask) == 32'h0 && l > bl) begin
                best = i;
                bl = l;
            end
        end
        e_vld = 1'b1;
        e_hit = (best >= 0);
        if (e_hit && m_act[best]) begin
            e_drop = 1'b0; e_nhop = m_nhop[best]; e_port = m_port[best]; e_ttl = ttl - 8'd1;
        end else begin
            e_drop = 1'b1; e_nhop = 32'h0; e_port = 4'h0; e_ttl = ttl;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if ({out_vld, out_drop, out_hit, out_nhop, out_port, out_ttl} !==
            {e_vld, e_drop, e_hit, e_nhop, e_port, e_ttl}) begin
            errors++;
            $display("FAIL %s dst=%h: got vld=%b drop=%b hit=%b nhop=%h port=%h ttl=%0d, exp vld=%b drop=%b hit=%b nhop=%h port=%h ttl=%0d",
                     tag, in_dst, out_vld, out_drop, out_hit, out_nhop, out_port, out_ttl,
                     e_vld, e_drop, e_hit, e_nhop, e_port, e_ttl);
        end
    endtask

    task automatic wr(input int idx, input logic v, input logic [31:0] p, input logic [5:0] l,
                      input logic a, input logic [31:0] nh, input logic [3:0] pt);
        @(negedge clk);
        in_vld = 1'b0;
        cp_wr_en = 1'b1; cp_wr_idx = 4'(idx); cp_wr_valid = v; cp_wr_prefix = p;
        cp_wr_len = l; cp_wr_act = a; cp_wr_nhop = nh; cp_wr_port = pt;
        @(posedge clk); #1;
        cp_wr_en = 1'b0;
        m_valid[idx] = v; m_prefix[idx] = p; m_len[idx] = l;
        m_act[idx] = a; m_nhop[idx] = nh; m_port[idx] = pt;
    endtask

    task automatic look(input logic [31:0] dst, input logic [7:0] ttl, input string tag);
        @(negedge clk);
        in_vld = 1'b1; in_dst = dst; in_ttl = ttl;
        ref_calc(dst, ttl);
        @(posedge clk); #1;
        check(tag);
    endtask

    task automatic depth_sweep(input string tag);
        for (int k = 0; k <= 32; k++) begin
            logic [31:0] d = (k == 32) ? BASE : (BASE ^ (32'h8000_0000 >> k));
            look(d, 8'(k * 7 + 1), tag);
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0;
        cp_wr_en = 0; cp_wr_idx = 0; cp_wr_valid = 0; cp_wr_prefix = 0; cp_wr_len = 0;
        cp_wr_act = 0; cp_wr_nhop = 0; cp_wr_port = 0;
        in_vld = 0; in_dst = 0; in_ttl = 0;
        for (int i = 0; i < NS; i++) begin
            m_valid[i] = 0; m_prefix[i] = 0; m_len[i] = 0; m_act[i] = 0; m_nhop[i] = 0; m_port[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        e_vld = 0; e_drop = 0; e_hit = 0; e_nhop = 0; e_port = 0; e_ttl = 0;
        check("R1 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;

        // empty table after reset: every key misses
        look(32'h0102_0304, 8'd64, "R1 R5 empty table");
        look(BASE, 8'd9, "R1 R5 empty table");

        // nested chain: slot i has length 2i+2, slot 15 length 40 (acts as 32)
        for (int i = 0; i < NS; i++) begin
            wr(i, 1'b1, BASE, (i == 15) ? 6'd40 : 6'(2 * i + 2), (i % 3 != 1),
               32'hC0A8_0000 + 32'(i), 4'(i));
        end
        depth_sweep("R2 R3 R4 R5 R6 R7 chain");
        look(BASE, 8'd0, "R7 ttl wrap");

        lfsr = 32'h1357_9BDF;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            look(BASE ^ (lfsr >> lfsr[4:0]), lfsr[15:8], "R3 R4 scrambled");
        end

        // slot 0 becomes a zero-length default route
        wr(0, 1'b1, 32'hFFFF_FFFF, 6'd0, 1'b1, 32'hDEAD_0001, 4'hE);
        depth_sweep("R3 default route");

        // removing the longest slot hands its keys to the next shorter one
        wr(15, 1'b0, BASE, 6'd32, 1'b1, 32'h0, 4'h0);
        look(BASE, 8'd50, "R8 removed slot");

        // equal lengths: lower index wins
        wr(9, 1'b1, TIEP, 6'd24, 1'b1, 32'h0909_0909, 4'h9);
        wr(3, 1'b1, TIEP, 6'd24, 1'b1, 32'h0303_0303, 4'h3);
        look(TIEP | 32'h11, 8'd33, "R4 tie lower index");
        wr(3, 1'b0, TIEP, 6'd24, 1'b1, 32'h0, 4'h0);
        look(TIEP | 32'h22, 8'd33, "R4 tie after removal");

        // write and lookup on the same edge: the lookup sees the old slot
        @(negedge clk);
        in_vld = 1'b1; in_dst = 32'h2B00_0007; in_ttl = 8'd77;
        ref_calc(32'h2B00_0007, 8'd77);
        cp_wr_en = 1'b1; cp_wr_idx = 4'd5; cp_wr_valid = 1'b1; cp_wr_prefix = 32'h2B00_0000;
        cp_wr_len = 6'd8; cp_wr_act = 1'b1; cp_wr_nhop = 32'h2B2B_2B2B; cp_wr_port = 4'h5;
        @(posedge clk); #1;
        cp_wr_en = 1'b0;
        check("R8 same-edge write unseen");
        m_valid[5] = 1; m_prefix[5] = 32'h2B00_0000; m_len[5] = 8; m_act[5] = 1;
        m_nhop[5] = 32'h2B2B_2B2B; m_port[5] = 4'h5;
        look(32'h2B00_0007, 8'd77, "R8 write seen next");

        // idle cycles hold everything but out_vld
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            in_vld = 1'b0; in_dst = 32'hFFFF_0000 + 32'(n); in_ttl = 8'(n);
            e_vld = 1'b0;
            @(posedge clk); #1;
            check("R9 idle hold");
        end

        summary();
    end

endmodule